// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block is the vector-priority core of a per-processor interrupt controller. It keeps three 256-entry bit arrays, each held as eight 32-bit words: pending requests, vectors in service, and the trigger mode each request arrived with. Sources post a vector with a level/edge flag. The block compares the highest pending vector against a processor priority and raises a registered pending line toward the CPU. The processor priority is derived from a software task priority and the highest in-service vector.

The CPU takes an interrupt with a one-cycle acknowledge pulse and reads the vector in that same cycle. If the request does not beat the task priority, the CPU gets the programmable spurious vector instead and nothing changes. Software retires the current handler with an end-of-interrupt write. It reads all arrays and control registers through a word-addressed register port that returns data one cycle later. A running count of newly latched requests is exported for monitoring.

Top module: `lipc_top`

## Requirements
- R1: After synchronous reset, the task priority (TPR) is 0, the spurious register reads 0x0FF (software disabled), all pending/in-service/trigger bits are clear, `irq_pending` is 0 and `delivered_count` is 0.
- R2: Vector v is held in bit (v mod 32) of word (v div 32). Array word w reads at address 0x08+w for in-service, 0x10+w for trigger mode and 0x18+w for pending. A request with `req_valid` sets the pending bit of `req_vector`.
- R3: A request with `req_level`=1 sets the trigger-mode bit of its vector, and a request with `req_level`=0 clears it.
- R4: The processor priority (PPR, read at address 0x01) equals TPR when TPR[7:4] is at least the class [7:4] of the highest in-service vector, treating an empty in-service array as class 0. Otherwise it equals that class shifted left by 4.
- R5: `irq_pending` is high exactly when, in the state of the previous cycle, the enable bit (spurious register bit 8) was set, some pending bit was set, and either PPR was 0 or the highest pending vector's class was strictly above PPR[7:4].
- R6: When `ack` is high, TPR is zero or below the highest pending vector, and the block is enabled, `ack_vector` shows that vector in the same cycle. Its pending bit is cleared and its in-service bit is set at the clock edge.
- R7: When `ack` is high and TPR is nonzero and at least the highest pending vector, or no bit is pending, or the block is disabled, `ack_vector` shows spurious bits [7:0] and no array bit changes.
- R8: A write to address 0x03 clears the highest set in-service bit, and has no effect when the in-service array is empty.
- R9: A write to address 0x02 stores `reg_wdata[8:0]` as the spurious register; bit 8 is the enable and [7:0] the spurious vector. A write to address 0x00 loads TPR from `reg_wdata[7:0]`.
- R10: `delivered_count` increments by one only when a request sets a pending bit that was clear, and holds otherwise.
- R11: `reg_rdata` shows, one clock after `reg_addr` is presented, the addressed register zero-extended. Unmapped addresses and address 0x03 read 0. Writes to any address other than 0x00, 0x02 and 0x03 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Post a vector request this cycle |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ack | input | 1 | CPU acknowledge pulse |
| ack_vector | output | 8 | Vector returned during `ack` |
| irq_pending | output | 1 | Registered interrupt request to the CPU |
| delivered_count | output | 16 | Count of newly latched requests |

## Verification
The spurious acknowledge is the hardest case to reach from the ports. It needs the block enabled, a non-empty pending array, and a task priority at or above the highest pending vector, with the equality case as the sharpest edge. Directed steps program TPR to exactly a pending vector's value and acknowledge. The random phase mixes TPR writes, requests across all classes, acknowledges and end-of-interrupt writes, so nested in-service vectors and refused acknowledges arise often. A reference model checks pending, count, acknowledge vector and array readback after each step.

// File: rtl/lipc_pkg.sv
package lipc_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_TPR = 6'h00;
  localparam logic [ADDR_W-1:0] A_PPR = 6'h01;
  localparam logic [ADDR_W-1:0] A_SVR = 6'h02;
  localparam logic [ADDR_W-1:0] A_EOI = 6'h03;

  typedef enum logic [2:0] {
    GRP_CTRL = 3'd0,
    GRP_ISR  = 3'd1,
    GRP_TMR  = 3'd2,
    GRP_IRR  = 3'd3
  } grp_e;
endpackage

// File: rtl/lipc_prio_enc.sv
module lipc_prio_enc #(
  parameter int unsigned N     = 256,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lipc_bit_array.sv
module lipc_bit_array #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NB    = WORDS * WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_mask,
  input  logic [NB-1:0] clr_mask,
  output logic [NB-1:0] bits
);
  logic [WORD_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) mem[w] <= '0;
      else mem[w] <= (mem[w] & ~clr_mask[w*WORD_W +: WORD_W]) | set_mask[w*WORD_W +: WORD_W];
    end
    assign bits[w*WORD_W +: WORD_W] = mem[w];
  end
endmodule

// File: rtl/lipc_top.sv
module lipc_top #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned NVEC  = 1 << VEC_W,
  localparam int unsigned WORDS = NVEC / WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [VEC_W-1:0]          req_vector,
  input  logic                      req_level,
  input  logic                      reg_wr,
  input  logic [lipc_pkg::ADDR_W-1:0] reg_addr,
  input  logic [VEC_W:0]            reg_wdata,
  output logic [WORD_W-1:0]         reg_rdata,
  input  logic                      ack,
  output logic [VEC_W-1:0]          ack_vector,
  output logic                      irq_pending,
  output logic [CNT_W-1:0]          delivered_count
);
  import lipc_pkg::*;

  localparam int unsigned CLS_LSB = VEC_W - 4;
  localparam int unsigned WSEL_W  = $clog2(WORDS);

  logic [NVEC-1:0]    irr_bits, isr_bits, tmr_bits;
  logic [VEC_W-1:0]   tpr_q;
  logic [VEC_W:0]     svr_q;
  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_hi, isr_hi;
  logic [3:0]         isr_cls;
  logic [VEC_W-1:0]   ppr;
  logic               take_ok, ack_take, pend_next;
  logic               wr_tpr, wr_svr, wr_eoi;
  logic [NVEC-1:0]    req_mask, take_mask, eoi_mask, lvl_set, lvl_clr;
  logic [WSEL_W-1:0]  wsel;
  grp_e               grp;

  lipc_prio_enc #(.N(NVEC), .IDX_W(VEC_W)) u_irr_enc (
    .bits(irr_bits), .found(irr_any), .idx(irr_hi));
  lipc_prio_enc #(.N(NVEC), .IDX_W(VEC_W)) u_isr_enc (
    .bits(isr_bits), .found(isr_any), .idx(isr_hi));

  assign isr_cls = isr_any ? isr_hi[VEC_W-1:CLS_LSB] : 4'd0;
  assign ppr     = (tpr_q[VEC_W-1:CLS_LSB] >= isr_cls) ? tpr_q
                                                       : {isr_cls, {CLS_LSB{1'b0}}};

  assign wr_tpr = reg_wr && (reg_addr == A_TPR);
  assign wr_svr = reg_wr && (reg_addr == A_SVR);
  assign wr_eoi = reg_wr && (reg_addr == A_EOI);

  assign take_ok    = svr_q[VEC_W] && irr_any && !((tpr_q != '0) && (irr_hi <= tpr_q));
  assign ack_take   = ack && take_ok;
  assign ack_vector = take_ok ? irr_hi : svr_q[VEC_W-1:0];

  assign req_mask  = req_valid ? (NVEC'(1) << req_vector) : '0;
  assign take_mask = ack_take ? (NVEC'(1) << irr_hi) : '0;
  assign eoi_mask  = (wr_eoi && isr_any) ? (NVEC'(1) << isr_hi) : '0;
  assign lvl_set   = req_mask & {NVEC{req_level}};
  assign lvl_clr   = req_mask & {NVEC{~req_level}};

  lipc_bit_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_irr (
    .clk(clk), .rst(rst), .set_mask(req_mask), .clr_mask(take_mask), .bits(irr_bits));
  lipc_bit_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_isr (
    .clk(clk), .rst(rst), .set_mask(take_mask), .clr_mask(eoi_mask), .bits(isr_bits));
  lipc_bit_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tmr (
    .clk(clk), .rst(rst), .set_mask(lvl_set), .clr_mask(lvl_clr), .bits(tmr_bits));

  assign pend_next = svr_q[VEC_W] && irr_any &&
                     ((ppr == '0) || (irr_hi[VEC_W-1:CLS_LSB] > ppr[VEC_W-1:CLS_LSB]));

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q           <= '0;
      svr_q           <= {1'b0, {VEC_W{1'b1}}};
      irq_pending     <= 1'b0;
      delivered_count <= '0;
    end else begin
      if (wr_tpr) tpr_q <= reg_wdata[VEC_W-1:0];
      if (wr_svr) svr_q <= reg_wdata;
      irq_pending <= pend_next;
      if (req_valid && !irr_bits[req_vector])
        delivered_count <= delivered_count + CNT_W'(1);
    end
  end

  assign grp  = grp_e'(reg_addr[ADDR_W-1:3]);
  assign wsel = reg_addr[WSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (grp)
        GRP_CTRL: begin
          case (reg_addr)
            A_TPR:   reg_rdata <= WORD_W'(tpr_q);
            A_PPR:   reg_rdata <= WORD_W'(ppr);
            A_SVR:   reg_rdata <= WORD_W'(svr_q);
            default: reg_rdata <= '0;
          endcase
        end
        GRP_ISR: reg_rdata <= isr_bits[int'(wsel)*WORD_W +: WORD_W];
        GRP_TMR: reg_rdata <= tmr_bits[int'(wsel)*WORD_W +: WORD_W];
        GRP_IRR: reg_rdata <= irr_bits[int'(wsel)*WORD_W +: WORD_W];
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lipc_chk.sv
module lipc_chk #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NVEC = 1 << VEC_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [VEC_W-1:0]            req_vector,
  input logic                        req_level,
  input logic                        reg_wr,
  input logic [lipc_pkg::ADDR_W-1:0] reg_addr,
  input logic                        ack,
  input logic [VEC_W-1:0]            ack_vector,
  input logic                        irq_pending,
  input logic [CNT_W-1:0]            delivered_count,
  input logic [NVEC-1:0]             irr_bits,
  input logic [NVEC-1:0]             isr_bits,
  input logic [NVEC-1:0]             tmr_bits,
  input logic [VEC_W:0]              svr_q
);
  p_req_sets_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> irr_bits[$past(req_vector)]);

  p_trig_mode_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (tmr_bits[$past(req_vector)] == $past(req_level)));

  p_pend_needs_state_r5: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> ($past(svr_q[VEC_W]) && $past(|irr_bits)));

  p_ack_moves_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && !req_valid && (ack_vector != svr_q[VEC_W-1:0])) |=>
      (isr_bits[$past(ack_vector)] && !irr_bits[$past(ack_vector)]));

  p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == lipc_pkg::A_EOI) && (|isr_bits) && !ack) |=>
      ($countones(isr_bits) == $countones($past(isr_bits)) - 1));

  p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
    (delivered_count == $past(delivered_count)) ||
    (delivered_count == $past(delivered_count) + CNT_W'(1)));

  p_count_cause_r10: assert property (@(posedge clk) disable iff (rst)
    (delivered_count != $past(delivered_count)) |-> $past(req_valid));
endmodule

bind lipc_top lipc_chk #(.VEC_W(VEC_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/lipc_top_tb_top.sv
module lipc_top_tb_top;
  import lipc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [8:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ack = 1'b0;
  logic [7:0]  ack_vector;
  logic        irq_pending;
  logic [15:0] delivered_count;

  int checks = 0;
  int fails  = 0;

  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0]   m_tpr;
  bit [8:0]   m_svr;
  bit [15:0]  m_cnt;

  always #10 clk = ~clk;

  lipc_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack),
    .ack_vector(ack_vector), .irq_pending(irq_pending),
    .delivered_count(delivered_count));

  function automatic int hi(bit [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic int ppr_f();
    int h = hi(m_isr);
    int c = (h < 0) ? 0 : (h >> 4);
    return ((m_tpr >> 4) >= c) ? int'(m_tpr) : (c << 4);
  endfunction

  function automatic bit pend_f();
    int h = hi(m_irr);
    int p = ppr_f();
    return m_svr[8] && (h >= 0) && ((p == 0) || ((h >> 4) > (p >> 4)));
  endfunction

  function automatic bit take_f();
    int h = hi(m_irr);
    return m_svr[8] && (h >= 0) && !((m_tpr != 0) && (h <= int'(m_tpr)));
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] a);
    int w = int'(a[2:0]);
    case (a[5:3])
      3'd0: case (a)
              6'h00: return 32'(m_tpr);
              6'h01: return 32'(ppr_f());
              6'h02: return 32'(m_svr);
              default: return 32'h0;
            endcase
      3'd1: return m_isr[w*32 +: 32];
      3'd2: return m_tmr[w*32 +: 32];
      3'd3: return m_irr[w*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic rd_chk(logic [5:0] a, string tag);
    logic [31:0] e;
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    e = exp_read(a);
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
    chk(irq_pending == pend_f(), "R5 pending", 32'(irq_pending), 32'(pend_f()));
    chk(delivered_count == m_cnt, "R10 count", 32'(delivered_count), 32'(m_cnt));
  endtask

  task automatic do_req(logic [7:0] v, logic lvl);
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (!m_irr[v]) m_cnt++;
    m_irr[v] = 1'b1;
    m_tmr[v] = lvl;
  endtask

  task automatic do_wr(logic [5:0] a, logic [8:0] d);
    int h;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    if (a == A_TPR) m_tpr = d[7:0];
    if (a == A_SVR) m_svr = d;
    if (a == A_EOI) begin
      h = hi(m_isr);
      if (h >= 0) m_isr[h] = 1'b0;
    end
  endtask

  task automatic do_ack();
    int h = hi(m_irr);
    bit t = take_f();
    logic [7:0] e = t ? 8'(h) : m_svr[7:0];
    ack = 1'b1;
    #1;
    chk(ack_vector == e, t ? "R6 ack vector" : "R7 spurious vector",
        32'(ack_vector), 32'(e));
    @(posedge clk); @(negedge clk);
    ack = 1'b0;
    if (t) begin
      m_irr[h] = 1'b0;
      m_isr[h] = 1'b1;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_svr = 9'h0FF; m_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(irq_pending == 1'b0, "R1 pending", 32'(irq_pending), 0);
    chk(delivered_count == 0, "R1 count", 32'(delivered_count), 0);
    rd_chk(6'h02, "R1 spurious reset");
    rd_chk(6'h00, "R1 tpr reset");
    for (int w = 0; w < 8; w++) rd_chk(6'h18 + 6'(w), "R1 irr reset");
    rd_chk(6'h2A, "R11 unmapped read");

    // R9 enable, R11 ignored write
    do_wr(6'h05, 9'h1AA); settle();
    rd_chk(6'h02, "R11 ignored write");
    do_wr(A_SVR, 9'h1F0); settle();
    rd_chk(6'h02, "R9 spurious write");

    // R2 R3 R10
    do_req(8'h45, 1'b0); settle();
    rd_chk(6'h1A, "R2 irr word 2");
    rd_chk(6'h12, "R3 edge tmr");
    do_req(8'h45, 1'b1); settle();
    rd_chk(6'h12, "R3 level tmr");

    // R6 R4
    do_ack(); settle();
    rd_chk(6'h0A, "R6 isr word 2");
    rd_chk(6'h01, "R4 ppr from isr");
    do_req(8'h43, 1'b0); settle();
    chk(irq_pending == 1'b0, "R5 same class blocked", 32'(irq_pending), 0);
    do_req(8'h52, 1'b0); settle();
    chk(irq_pending == 1'b1, "R5 higher class", 32'(irq_pending), 1);
    do_ack(); settle();
    rd_chk(6'h01, "R4 ppr nested");

    // R8 nested EOIs then empty
    do_wr(A_EOI, 9'h0); settle();
    rd_chk(6'h0A, "R8 eoi highest");
    do_wr(A_EOI, 9'h0); settle();
    do_wr(A_EOI, 9'h0); settle();
    rd_chk(6'h0A, "R8 eoi empty");

    // R7 tpr equal to pending vector
    do_wr(A_TPR, 9'h043); settle();
    rd_chk(6'h01, "R4 ppr from tpr");
    do_ack(); settle();
    rd_chk(6'h1A, "R7 irr unchanged");
    do_wr(A_TPR, 9'h000);
    do_wr(A_SVR, 9'h0AB); settle();
    do_ack(); settle();
    rd_chk(6'h1A, "R7 disabled no change");
    do_wr(A_SVR, 9'h1FF); settle();

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom_range(0, 99);
      if (op < 40) do_req(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      else if (op < 62) do_ack();
      else if (op < 80) do_wr(A_EOI, 9'h0);
      else if (op < 92) do_wr(A_TPR, 9'($urandom_range(0, 255)));
      else if (op < 96) do_wr(A_SVR, {1'b1, 8'($urandom_range(0, 255))});
      else do_wr(A_SVR, {1'($urandom_range(0, 1)), 8'($urandom_range(0, 255))});
      settle();
      if ((n % 3) == 0)
        rd_chk({3'($urandom_range(0, 3)), 3'($urandom_range(0, 7))}, "R11 random read");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule